// File: doc/BRIEF.md
# Mode-Selectable Output Post-Divider

This block derives one output clock from a fast oscillator clock. A 2-bit mode code picks the behaviour. The four choices are: output held quiet, input clock passed through unchanged, a fixed halving, or a division by a programmed 10-bit value plus two. The divider can be programmed with any value from 1 to 1023, so the programmable ratio runs from 3 to 1025. A value of 0 gives a ratio of 2.

The mode code and the divide value are static configuration pins. They are not a data stream, so the block has no valid/ready handshake and applies no back-pressure. The block samples both pins only at the end of an output period: after the high phase of a divided clock, or on any input cycle while the output is quiet or passing through. A change made in the middle of a period therefore never shortens a pulse or adds a stray one. Each divided period starts with its low phase, and the low phase is the longer half when the ratio is odd. In the quiet mode the block keeps running from its clock and simply holds the output low.

Top module: `vco_postdiv`

## Requirements
- R1: With mode code 00 the output stays low on every half of every input cycle.
- R2: With mode code 01 the output is high while the input clock is high and low while it is low.
- R3: With mode code 10 the output has a period of two input cycles, with one cycle low followed by one cycle high.
- R4: With mode code 11 and divide value q, the output period is q+2 input cycles; for an even ratio the low and high phases are equal.
- R5: For an odd ratio N, the output is low for (N+1)/2 input cycles and then high for (N-1)/2 input cycles.
- R6: While reset is low the output is low. The first rising input edge after release loads the configuration, and the first output rise follows after the full low phase of the selected ratio.
- R7: The mode and divide value are loaded only on the rising input edge that ends an output period (the edge that ends the high phase, or any edge in modes 00 and 01); changes at other times have no effect until then.
- R8: Switching between pass-through and a divided mode produces only full-width pulses: the last pass-through pulse is complete, and after a divided period ends the first pass-through pulse starts one full input cycle later.
- R9: The largest divide value, 1023, gives a period of 1025 input cycles, made of 513 low cycles followed by 512 high cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode code: 00 quiet, 01 pass-through, 10 halve, 11 divide by q+2 |
| q_i | input | QW (10) | Programmable divide value q |
| clk_o | output | 1 | Divided output clock |

## Verification
A mode or divide value presented before an end-of-period rising edge is loaded on that edge. The divided output then starts its low phase on the same edge, and it rises on the edge where the count of cycles since the load reaches the low-phase length. A switch into pass-through appears only after the following falling edge, so the first full pass-through pulse comes one input cycle after the load. The bench holds a behavioural model that follows these edge counts. It samples the output 2 ns after every rising edge and every falling edge, which puts one sample in the middle of each clock half, and compares each sample with the model. Inputs change 4 ns after a rising edge, away from any sampling point.

// File: rtl/vco_postdiv_pkg.sv
package vco_postdiv_pkg;
  typedef enum logic [1:0] {
    PD_OFF  = 2'b00,
    PD_PASS = 2'b01,
    PD_HALF = 2'b10,
    PD_PROG = 2'b11
  } pd_mode_e;
endpackage

// File: rtl/postdiv_cfg.sv
// Holds the active configuration; reloads only when the phase logic says a
// period has ended. Derives the ratio and low-phase length from it.
module postdiv_cfg
  import vco_postdiv_pkg::*;
#(
  parameter int QW = 10,
  parameter int CW = QW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [1:0]    mode_i,
  input  logic [QW-1:0] q_i,
  output pd_mode_e      act_mode_o,
  output logic [CW-1:0] ratio_o,
  output logic [CW-1:0] low_len_o
);
  pd_mode_e      mode_q;
  logic [QW-1:0] val_q;
  logic [CW:0]   ratio_p1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PD_OFF;
      val_q  <= '0;
    end else if (load_i) begin
      mode_q <= pd_mode_e'(mode_i);
      val_q  <= q_i;
    end
  end

  always_comb begin
    case (mode_q)
      PD_HALF: ratio_o = CW'(2);
      PD_PROG: ratio_o = CW'(val_q) + CW'(2);
      default: ratio_o = CW'(1);
    endcase
  end

  // low phase = ceil(ratio / 2)
  assign ratio_p1   = {1'b0, ratio_o} + (CW+1)'(1);
  assign low_len_o  = ratio_p1[CW:1];
  assign act_mode_o = mode_q;
endmodule

// File: rtl/postdiv_phase.sv
// Counts input cycles within one output period and produces the divided level.
module postdiv_phase
  import vco_postdiv_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  pd_mode_e      act_mode_i,
  input  logic [CW-1:0] ratio_i,
  input  logic [CW-1:0] low_len_i,
  output logic          load_o,
  output logic [CW-1:0] cnt_o,
  output logic          div_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic          div_q;
  logic          undivided;

  assign undivided = (act_mode_i == PD_OFF) || (act_mode_i == PD_PASS);
  assign load_o    = undivided || (cnt_q == ratio_i - CW'(1));
  assign cnt_nxt   = cnt_q + CW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (load_o) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      div_q <= (cnt_nxt >= low_len_i);
    end
  end

  assign cnt_o = cnt_q;
  assign div_o = div_q;
endmodule

// File: rtl/postdiv_pass_gate.sv
// Enable for the pass-through path, updated only while the input clock is low.
module postdiv_pass_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pass_i,
  output logic gate_o
);
  logic gate_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= pass_i;
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/vco_postdiv.sv
module vco_postdiv
  import vco_postdiv_pkg::*;
#(
  parameter int QW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic [QW-1:0] q_i,
  output logic          clk_o
);
  localparam int CW = QW + 1;

  pd_mode_e      act_mode;
  logic [CW-1:0] ratio;
  logic [CW-1:0] low_len;
  logic [CW-1:0] cnt;
  logic          load;
  logic          div_q;
  logic          gate;

  postdiv_cfg #(.QW(QW), .CW(CW)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .mode_i     (mode_i),
    .q_i        (q_i),
    .act_mode_o (act_mode),
    .ratio_o    (ratio),
    .low_len_o  (low_len)
  );

  postdiv_phase #(.CW(CW)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_mode_i (act_mode),
    .ratio_i    (ratio),
    .low_len_i  (low_len),
    .load_o     (load),
    .cnt_o      (cnt),
    .div_o      (div_q)
  );

  postdiv_pass_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pass_i (act_mode == PD_PASS),
    .gate_o (gate)
  );

  assign clk_o = (clk_i & gate) | div_q;
endmodule

// File: rtl/vco_postdiv_chk.sv
module vco_postdiv_chk
  import vco_postdiv_pkg::*;
#(
  parameter int CW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input pd_mode_e      act_mode,
  input logic [CW-1:0] ratio,
  input logic [CW-1:0] low_len,
  input logic [CW-1:0] cnt,
  input logic          div_q
);
  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode == PD_OFF) |-> !div_q);

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < ratio);

  p_rise_mid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_q) |-> (cnt == low_len) && act_mode[1]);

  p_fall_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div_q) |-> (cnt == '0));

  p_hold_cfg_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != '0) |-> ($stable(act_mode) && $stable(ratio)));

  p_pass_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mode == PD_PASS) |-> !div_q);
endmodule

bind vco_postdiv vco_postdiv_chk #(.CW(CW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .act_mode (act_mode),
  .ratio    (ratio),
  .low_len  (low_len),
  .cnt      (cnt),
  .div_q    (div_q)
);

// File: tb/tb_vco_postdiv.sv
module tb_vco_postdiv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [9:0] q = '0;
  logic       clk_o;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag = "R6";

  // behavioural reference
  int m_mode = 0;
  int m_n = 1;
  int m_pos = 0;
  bit m_out = 1'b0;
  bit m_gate = 1'b0;

  vco_postdiv dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .mode_i (mode),
    .q_i    (q),
    .clk_o  (clk_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_n = 1; m_pos = 0; m_out = 1'b0;
    end else begin
      if (m_mode < 2 || m_pos == m_n - 1) begin
        m_mode = int'(mode);
        m_n    = (m_mode == 2) ? 2 : (m_mode == 3) ? int'(q) + 2 : 1;
        m_pos  = 0;
      end else begin
        m_pos = m_pos + 1;
      end
      // low for ceil(n/2) cycles, then high for floor(n/2)
      m_out = (m_mode >= 2) && (m_pos >= m_n - m_n / 2);
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) m_gate = 1'b0;
    else        m_gate = (m_mode == 1);
  end

  task automatic chk(input bit got, input bit exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: clk_o=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    forever begin
      @(posedge clk); #2;
      chk(clk_o, m_out | m_gate);
      @(negedge clk); #2;
      chk(clk_o, m_out);
    end
  end

  task automatic step(input logic [1:0] md, input logic [9:0] qv,
                      input int cyc, input string t);
    @(posedge clk); #4;
    mode = md; q = qv; tag = t;
    repeat (cyc) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R6: reset state, then ratio 5 loaded at the first edge
    mode = 2'b11; q = 10'd3;
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    repeat (14) @(posedge clk);
    step(2'b10, 10'd0,    20,   "R3");
    step(2'b11, 10'd4,    40,   "R4");
    step(2'b11, 10'd0,    12,   "R4");
    step(2'b11, 10'd5,    40,   "R5");
    step(2'b11, 10'd7,    3,    "R7");
    step(2'b11, 10'd1,    30,   "R7");
    step(2'b01, 10'd0,    20,   "R2");
    step(2'b11, 10'd2,    20,   "R8");
    step(2'b01, 10'd0,    10,   "R8");
    step(2'b10, 10'd0,    6,    "R8");
    step(2'b00, 10'd9,    20,   "R1");
    step(2'b11, 10'd1023, 2200, "R9");
    // R6: reset in mid-period
    @(posedge clk); #4;
    tag = "R6"; rst_n = 1'b0; mode = 2'b11; q = 10'd2;
    repeat (3) @(posedge clk);
    #4 rst_n = 1'b1;
    repeat (15) @(posedge clk);
    #8;
    summary();
    $finish;
  end
endmodule